// File: doc/BRIEF.md
# Strap-Addressed I2C Control Register File

This block is an I2C target that holds the eight 8-bit control registers of a video splitter running in register-programmed mode. It samples the raw SCL and SDA lines, cleans them with a synchronizer and a three-sample majority filter, and finds start and stop conditions. It answers a 7-bit device address made of a fixed `101` prefix and four strap pins. It then serves multi-byte writes and reads through an auto-incrementing register pointer.

The register contents are always visible as a flat parallel bus. Two fields are also decoded for the analog side: the receive equalizer step and a saturated pre-emphasis level for each output port. Register 6 combines one stored control bit with the live hot-plug inputs of the four sinks. The open-drain pad is outside the block: `sda_oe_o` high means "pull SDA low". SCL is never stretched.

Top module: `ctl_regfile_i2c`

## Requirements
- R1: The target acknowledges an address byte only when its upper seven bits equal `1,0,1,A3,A2,A1,A0` (A = `addr_strap_i`). Bit 0 selects the direction (1 = read, 0 = write). On any other address it stays silent and ignores the rest of the transaction until the next start.
- R2: After reset, register 0 reads 0xFF and registers 1 to 7 read 0x00, apart from the live status bits of register 6.
- R3: In a write, the first data byte loads the register pointer (its low three bits). Each later byte is written at the pointer, and the pointer then advances, wrapping from 7 to 0. Every byte of a matched write is acknowledged.
- R4: A read returns bytes starting at the current pointer and advances the pointer after each byte, wrapping from 7 to 0. It continues while the master acknowledges and stops sending after a NACK.
- R5: `sda_oe_o` rises and falls only while the filtered SCL is low. It is released after every acknowledge slot, after a NACK and on a stop. It is low after reset.
- R6: Register 6 reads as {stored bit 7, three zeros, `hp_sink_i[3:0]`}. The low nibble follows the inputs live. Writes reach bit 7 only.
- R7: `eq_step_o` equals bits [4:2] of register 1 (step n selects 2.5·(n+1) dB).
- R8: For port p, `emph_lvl_o[3p+2:3p]` takes bits [6:4] of register 2+p. Codes 000 to 011 give levels 0 to 3, and any code 1xx gives level 4, the maximum.
- R9: While `mode_i2c_i` is 0 the target never drives SDA and no register changes.
- R10: A pulse on SCL that lasts a single clock cycle is filtered out and does not count as a bit.
- R11: A repeated start restarts the address phase and keeps the pointer, so a write of only a pointer byte followed by a repeated-start read reads from that pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| mode_i2c_i | input | 1 | 1 = register-programmed mode, target active |
| addr_strap_i | input | 4 | Low four bits of the device address |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe_o | output | 1 | 1 = pull SDA low |
| hp_sink_i | input | 4 | Live hot-plug level of sinks 4..1 (bit 0 = sink 1) |
| regs_o | output | 64 | Register contents, register k at bits [8k+7:8k] |
| eq_step_o | output | 3 | Receive equalizer step |
| emph_lvl_o | output | 12 | Pre-emphasis level 0..4 per port, 3 bits each |

## Verification
The bench writes across the 7-to-0 boundary and reads across it after a repeated start. A pointer that saturates or resets would return the wrong third byte, and a design that cleared the pointer on a restart would read from register 0. It drives an address that differs from the strap in a single bit and shows that the following data is ignored. It writes all ones to register 6 while the hot-plug inputs are set, then changes them, to catch a design that stores the status bits or samples them once. A one-cycle SCL glitch inside each bit of a byte would shift in extra bits if the filter were missing. Pre-emphasis codes 011 and 101 tell a saturating decode from a truncating one.

// File: rtl/cri_pkg.sv
package cri_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_ADDR,
        S_AACK,
        S_WBYTE,
        S_WACK,
        S_RBYTE,
        S_RACK
    } bus_st_e;
endpackage

// File: rtl/cri_glitch_filt.sv
module cri_glitch_filt (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic filt_o
);
    typedef struct packed {
        logic [1:0] sync;
        logic [2:0] win;
    } filt_t;

    filt_t d, q;

    always_comb begin
        d      = q;
        d.sync = {q.sync[0], raw_i};
        d.win  = {q.win[1:0], q.sync[1]};
    end

    // majority of the last three synchronized samples
    assign filt_o = (q.win[0] & q.win[1]) | (q.win[0] & q.win[2]) | (q.win[1] & q.win[2]);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= d;
    end
endmodule

// File: rtl/cri_bus_engine.sv
module cri_bus_engine #(
    parameter int PW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en_i,
    input  logic          scl_f,
    input  logic          sda_f,
    input  logic [6:0]    dev_addr_i,
    input  logic [7:0]    rd_byte_i,
    output logic          sda_oe_o,
    output logic [PW-1:0] ptr_o,
    output logic          wr_en_o,
    output logic [7:0]    wr_data_o
);
    import cri_pkg::*;

    typedef struct packed {
        bus_st_e       st;
        logic [3:0]    cnt;
        logic [7:0]    sh;
        logic [PW-1:0] ptr;
        logic          first;
        logic          rw;
        logic          nack;
        logic          sda_oe;
        logic          scl_p;
        logic          sda_p;
    } eng_t;

    eng_t d, q;
    logic rise, fall, start, stop;

    assign rise  = scl_f & ~q.scl_p;
    assign fall  = ~scl_f & q.scl_p;
    assign start = scl_f & q.scl_p & ~sda_f & q.sda_p;
    assign stop  = scl_f & q.scl_p & sda_f & ~q.sda_p;

    always_comb begin
        d         = q;
        d.scl_p   = scl_f;
        d.sda_p   = sda_f;
        wr_en_o   = 1'b0;
        wr_data_o = q.sh;
        if (!en_i) begin
            d.st     = S_IDLE;
            d.sda_oe = 1'b0;
            d.cnt    = '0;
        end else if (start) begin
            d.st     = S_ADDR;
            d.cnt    = '0;
            d.sda_oe = 1'b0;
        end else if (stop) begin
            d.st     = S_IDLE;
            d.sda_oe = 1'b0;
        end else begin
            unique case (q.st)
                S_ADDR, S_WBYTE: begin
                    if (rise && q.cnt < 4'd8) begin
                        d.sh  = {q.sh[6:0], sda_f};
                        d.cnt = q.cnt + 4'd1;
                    end
                    if (fall && q.cnt == 4'd8) begin
                        d.cnt = '0;
                        if (q.st == S_ADDR) begin
                            if (q.sh[7:1] == dev_addr_i) begin
                                d.st     = S_AACK;
                                d.sda_oe = 1'b1;
                                d.rw     = q.sh[0];
                                d.first  = 1'b1;
                            end else begin
                                d.st = S_IDLE;
                            end
                        end else begin
                            d.st     = S_WACK;
                            d.sda_oe = 1'b1;
                            if (q.first) begin
                                d.ptr   = q.sh[PW-1:0];
                                d.first = 1'b0;
                            end else begin
                                wr_en_o = 1'b1;
                                d.ptr   = q.ptr + 1'b1;
                            end
                        end
                    end
                end
                S_AACK: begin
                    if (fall) begin
                        d.cnt = '0;
                        if (q.rw) begin
                            d.st     = S_RBYTE;
                            d.sh     = rd_byte_i;
                            d.sda_oe = ~rd_byte_i[7];
                        end else begin
                            d.st     = S_WBYTE;
                            d.sda_oe = 1'b0;
                        end
                    end
                end
                S_WACK: begin
                    if (fall) begin
                        d.st     = S_WBYTE;
                        d.sda_oe = 1'b0;
                    end
                end
                S_RBYTE: begin
                    if (rise) d.cnt = q.cnt + 4'd1;
                    if (fall) begin
                        if (q.cnt == 4'd8) begin
                            d.st     = S_RACK;
                            d.sda_oe = 1'b0;
                            d.ptr    = q.ptr + 1'b1;
                        end else begin
                            d.sh     = {q.sh[6:0], 1'b0};
                            d.sda_oe = ~q.sh[6];
                        end
                    end
                end
                S_RACK: begin
                    if (rise) d.nack = sda_f;
                    if (fall) begin
                        d.cnt = '0;
                        if (!q.nack) begin
                            d.st     = S_RBYTE;
                            d.sh     = rd_byte_i;
                            d.sda_oe = ~rd_byte_i[7];
                        end else begin
                            d.st = S_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    assign sda_oe_o = q.sda_oe;
    assign ptr_o    = q.ptr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q       <= '0;
            q.st    <= S_IDLE;
            q.scl_p <= 1'b1;
            q.sda_p <= 1'b1;
        end else begin
            q <= d;
        end
    end
endmodule

// File: rtl/cri_reg_bank.sv
module cri_reg_bank #(
    parameter int NREG      = 8,
    parameter int DW        = 8,
    parameter int NPORT     = 4,
    parameter int EQ_IDX    = 1,
    parameter int PORT_BASE = 2,
    parameter int HP_IDX    = 6,
    localparam int PW       = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 we_i,
    input  logic [PW-1:0]        waddr_i,
    input  logic [DW-1:0]        wdata_i,
    input  logic [PW-1:0]        raddr_i,
    input  logic [NPORT-1:0]     hp_i,
    output logic [DW-1:0]        rdata_o,
    output logic [NREG*DW-1:0]   view_o,
    output logic [NREG*DW-1:0]   store_o,
    output logic [2:0]           eq_o,
    output logic [3*NPORT-1:0]   emph_o
);
    typedef logic [NREG-1:0][DW-1:0] bank_t;

    function automatic logic [DW-1:0] rst_val(input int idx);
        return (idx == 0) ? {DW{1'b1}} : '0;
    endfunction

    function automatic logic [DW-1:0] wr_mask(input int idx);
        return (idx == HP_IDX) ? {1'b1, {(DW-1){1'b0}}} : {DW{1'b1}};
    endfunction

    bank_t store_d, store_q, view;

    always_comb begin
        store_d = store_q;
        for (int i = 0; i < NREG; i++) begin
            if (we_i && waddr_i == PW'(i)) store_d[i] = wdata_i & wr_mask(i);
        end
    end

    for (genvar g = 0; g < NREG; g++) begin : g_view
        if (g == HP_IDX) begin : g_live
            assign view[g] = store_q[g] | {{(DW-NPORT){1'b0}}, hp_i};
        end else begin : g_plain
            assign view[g] = store_q[g];
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_emph
        logic [2:0] code;
        assign code = store_q[PORT_BASE+p][6:4];
        assign emph_o[3*p +: 3] = code[2] ? 3'd4 : {1'b0, code[1:0]};
    end

    assign rdata_o = view[raddr_i];
    assign view_o  = view;
    assign store_o = store_q;
    assign eq_o    = store_q[EQ_IDX][4:2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) store_q[i] <= rst_val(i);
        end else begin
            store_q <= store_d;
        end
    end
endmodule

// File: rtl/ctl_regfile_i2c.sv
module ctl_regfile_i2c #(
    parameter int         NREG       = 8,
    parameter int         DW         = 8,
    parameter int         NPORT      = 4,
    parameter logic [2:0] DEV_PREFIX = 3'b101,
    localparam int        PW         = $clog2(NREG)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 mode_i2c_i,
    input  logic [3:0]           addr_strap_i,
    input  logic                 scl_i,
    input  logic                 sda_i,
    output logic                 sda_oe_o,
    input  logic [NPORT-1:0]     hp_sink_i,
    output logic [NREG*DW-1:0]   regs_o,
    output logic [2:0]           eq_step_o,
    output logic [3*NPORT-1:0]   emph_lvl_o
);
    logic [1:0]         raw, filt;
    logic               scl_f, sda_f;
    logic [PW-1:0]      ptr;
    logic               wr_en;
    logic [DW-1:0]      wr_data, rd_data;
    logic [NREG*DW-1:0] store_w;

    assign raw = {sda_i, scl_i};
    for (genvar g = 0; g < 2; g++) begin : g_line
        cri_glitch_filt u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw[g]),
            .filt_o (filt[g])
        );
    end
    assign scl_f = filt[0];
    assign sda_f = filt[1];

    cri_bus_engine #(.PW(PW)) u_eng (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (mode_i2c_i),
        .scl_f      (scl_f),
        .sda_f      (sda_f),
        .dev_addr_i ({DEV_PREFIX, addr_strap_i}),
        .rd_byte_i  (rd_data),
        .sda_oe_o   (sda_oe_o),
        .ptr_o      (ptr),
        .wr_en_o    (wr_en),
        .wr_data_o  (wr_data)
    );

    cri_reg_bank #(.NREG(NREG), .DW(DW), .NPORT(NPORT)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .we_i    (wr_en),
        .waddr_i (ptr),
        .wdata_i (wr_data),
        .raddr_i (ptr),
        .hp_i    (hp_sink_i),
        .rdata_o (rd_data),
        .view_o  (regs_o),
        .store_o (store_w),
        .eq_o    (eq_step_o),
        .emph_o  (emph_lvl_o)
    );
endmodule

// File: rtl/cri_checker.sv
module cri_checker #(
    parameter int W = 64
) (
    input logic         clk,
    input logic         rst_n,
    input logic         mode_i,
    input logic         scl_f,
    input logic         sda_f,
    input logic         sda_oe,
    input logic [W-1:0] store
);
    // R5: the data line is only taken or released while the clock is low
    a_r5_drive_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i && $past(mode_i) && ($rose(sda_oe) || $fell(sda_oe))) |-> !scl_f);

    // R5: a stop condition leaves the line released
    a_r5_release_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f) && sda_f && !$past(sda_f)) |=> !sda_oe);

    // R9: pin mode keeps the line released
    a_r9_quiet_pin_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_i |=> !sda_oe);

    // R9: pin mode keeps the stored registers frozen
    a_r9_frozen_pin_mode: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(mode_i) |-> (store == $past(store)));

    // R3: register writes land only in the clock-low phase
    a_r3_write_scl_low: assert property (@(posedge clk) disable iff (!rst_n)
        (store != $past(store)) |-> !scl_f);
endmodule

bind ctl_regfile_i2c cri_checker #(.W(64)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .mode_i (mode_i2c_i),
    .scl_f  (scl_f),
    .sda_f  (sda_f),
    .sda_oe (sda_oe_o),
    .store  (store_w)
);

// File: tb/tb_ctl_regfile_i2c.sv
`timescale 1ns/1ps
module tb_ctl_regfile_i2c;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mode = 1'b1;
    logic [3:0]  strap = 4'b0110;
    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic [3:0]  hp = 4'b0000;
    logic        sda_oe;
    logic [63:0] regs;
    logic [2:0]  eq;
    logic [11:0] emph;
    logic        sda_line;
    int          checks = 0;
    int          fails = 0;

    localparam logic [7:0] AW = {3'b101, 4'b0110, 1'b0};
    localparam logic [7:0] AR = {3'b101, 4'b0110, 1'b1};

    always #2.5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    ctl_regfile_i2c dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .mode_i2c_i   (mode),
        .addr_strap_i (strap),
        .scl_i        (scl_m),
        .sda_i        (sda_line),
        .sda_oe_o     (sda_oe),
        .hp_sink_i    (hp),
        .regs_o       (regs),
        .eq_step_o    (eq),
        .emph_lvl_o   (emph)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] reg_at(input int k);
        return regs[8*k +: 8];
    endfunction

    task automatic bus_start();
        sda_m = 1'b1; tick(10);
        scl_m = 1'b1; tick(10);
        sda_m = 1'b0; tick(10);
        scl_m = 1'b0; tick(4);
    endtask

    task automatic bus_stop();
        tick(2); sda_m = 1'b0; tick(8);
        scl_m = 1'b1; tick(10);
        sda_m = 1'b1; tick(10);
    endtask

    task automatic send_bit(input logic b, input bit glitch);
        tick(2); sda_m = b; tick(4);
        if (glitch) begin
            scl_m = 1'b1; tick(1); scl_m = 1'b0;
        end
        tick(4);
        scl_m = 1'b1; tick(10);
        scl_m = 1'b0;
    endtask

    task automatic get_bit(output logic b);
        tick(2); sda_m = 1'b1; tick(8);
        scl_m = 1'b1; tick(5);
        b = sda_line; tick(5);
        scl_m = 1'b0;
    endtask

    task automatic wr_byte(input logic [7:0] v, input bit glitch, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(v[i], glitch);
        get_bit(ack);
    endtask

    task automatic rd_byte(input logic nack, output logic [7:0] v);
        for (int i = 7; i >= 0; i--) get_bit(v[i]);
        send_bit(nack, 1'b0);
    endtask

    // address, pointer and up to three data bytes; returns OR of all ack bits (0 = all acked)
    task automatic write_seq(input logic [7:0] addr, input logic [7:0] p,
                             input logic [7:0] d0, input logic [7:0] d1, input logic [7:0] d2,
                             input int n, input bit glitch, input bit do_stop, output logic anynack);
        logic a;
        logic [7:0] dat [3];
        dat[0] = d0; dat[1] = d1; dat[2] = d2;
        bus_start();
        wr_byte(addr, glitch, a); anynack = a;
        wr_byte(p, glitch, a);    anynack |= a;
        for (int i = 0; i < n; i++) begin
            wr_byte(dat[i], glitch, a);
            anynack |= a;
        end
        if (do_stop) bus_stop();
    endtask

    task automatic t_reset();
        chk("R2 reg0 reset", reg_at(0), 8'hFF);
        for (int k = 1; k < 8; k++) chk("R2 regk reset", reg_at(k), 8'h00);
        chk("R5 released after reset", sda_oe, 1'b0);
    endtask

    task automatic t_write_basic();
        logic nk;
        write_seq(AW, 8'h01, 8'h14, 8'h50, 8'h33, 3, 1'b0, 1'b1, nk);
        chk("R3 all bytes acked", nk, 1'b0);
        chk("R3 reg1", reg_at(1), 8'h14);
        chk("R3 reg2", reg_at(2), 8'h50);
        chk("R3 reg3", reg_at(3), 8'h33);
        chk("R7 eq step", eq, 3'd5);
        chk("R8 emph levels", emph, 12'h01C);
        chk("R5 released after stop", sda_oe, 1'b0);
    endtask

    task automatic t_wrap_status();
        logic nk;
        hp = 4'b1010;
        write_seq(AW, 8'h06, 8'hFF, 8'hA5, 8'h3C, 3, 1'b0, 1'b1, nk);
        chk("R3 wrap write acked", nk, 1'b0);
        chk("R6 reg6 merged", reg_at(6), 8'h8A);
        chk("R3 reg7", reg_at(7), 8'hA5);
        chk("R3 wrap to reg0", reg_at(0), 8'h3C);
        hp = 4'b0101; tick(2);
        chk("R6 live status", reg_at(6), 8'h85);
    endtask

    task automatic t_read();
        logic nk, a;
        logic [7:0] v;
        write_seq(AW, 8'h07, 8'h00, 8'h00, 8'h00, 0, 1'b0, 1'b0, nk);
        bus_start();
        wr_byte(AR, 1'b0, a);
        chk("R11 read address acked after restart", a, 1'b0);
        rd_byte(1'b0, v); chk("R11 first read from kept pointer", v, 8'hA5);
        rd_byte(1'b0, v); chk("R4 read wraps to reg0", v, 8'h3C);
        rd_byte(1'b1, v); chk("R4 read increments", v, 8'h14);
        chk("R5 released after nack", sda_oe, 1'b0);
        bus_stop();
        write_seq(AW, 8'h06, 8'h00, 8'h00, 8'h00, 0, 1'b0, 1'b0, nk);
        bus_start();
        wr_byte(AR, 1'b0, a);
        rd_byte(1'b1, v); chk("R6 status read over bus", v, 8'h85);
        bus_stop();
    endtask

    task automatic t_bad_addr();
        logic nk, a;
        bus_start();
        wr_byte({3'b101, 4'b0111, 1'b0}, 1'b0, a);
        chk("R1 strap mismatch not acked", a, 1'b1);
        wr_byte(8'h01, 1'b0, a);
        wr_byte(8'hEE, 1'b0, a);
        chk("R1 data after mismatch not acked", a, 1'b1);
        bus_stop();
        chk("R1 reg1 untouched", reg_at(1), 8'h14);
        write_seq({3'b111, 4'b0110, 1'b0}, 8'h01, 8'h77, 8'h00, 8'h00, 1, 1'b0, 1'b1, nk);
        chk("R1 prefix mismatch not acked", nk, 1'b1);
        chk("R1 reg1 still untouched", reg_at(1), 8'h14);
    endtask

    task automatic t_glitch();
        logic nk;
        write_seq(AW, 8'h02, 8'h5A, 8'h00, 8'h00, 1, 1'b1, 1'b1, nk);
        chk("R10 glitched write acked", nk, 1'b0);
        chk("R10 glitched write data", reg_at(2), 8'h5A);
    endtask

    task automatic t_pin_mode();
        logic nk;
        mode = 1'b0; tick(4);
        write_seq(AW, 8'h01, 8'hFF, 8'h00, 8'h00, 1, 1'b0, 1'b1, nk);
        chk("R9 no ack in pin mode", nk, 1'b1);
        chk("R9 reg1 unchanged", reg_at(1), 8'h14);
        chk("R9 line released", sda_oe, 1'b0);
        mode = 1'b1; tick(4);
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(10);
        t_reset();
        t_write_basic();
        t_wrap_status();
        t_read();
        t_bad_addr();
        t_glitch();
        t_pin_mode();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end
endmodule